// File: doc/BRIEF.md
# Branch Target Buffer

This block is a small direct-mapped cache of jump targets that sits beside instruction fetch. Each cycle fetch may present the address it is about to fetch. One cycle later the block reports whether a jump at that address has been seen before. On a hit it also gives the target recorded for that jump and a hint on whether to redirect. Fetch can then steer to the predicted address long before the jump reaches execute.

When a jump resolves in the execute stage, the resolved address, real target, outcome and jump kind are sent back. A jump that is not yet in the table is allocated into the slot its address selects and evicts whatever was there. A jump that is already present has its target refreshed and its 2-bit bias counter stepped toward the outcome. Conditional hits predict taken only while the counter is in the upper half of its range. Unconditional hits always predict taken.

Top module: `btb_top`

## Requirements
- R1: After reset every entry is invalid: every lookup misses, and `pred_hit`, `pred_taken` and `pred_target` are 0.
- R2: A lookup presented with `lu_valid` high is answered in the next cycle. A cycle without a lookup is followed by a cycle with `pred_hit` and `pred_taken` low.
- R3: The entry is selected by `pc[ALIGN_W+IDX_W-1:ALIGN_W]`, and the remaining upper bits `pc[ADDR_W-1:ALIGN_W+IDX_W]` form the tag. A hit needs a valid entry whose tag equals the lookup tag, so an address that differs only in a tag bit misses.
- R4: A resolution with no matching entry allocates one: it marks the entry valid and stores the tag, target and kind. The counter starts at 2 if the jump was taken and at 1 if not. The lookup that preceded this first resolution got no prediction.
- R5: A hitting lookup outputs the stored target on `pred_target`.
- R6: A resolution whose address maps to an occupied entry with a different tag replaces that entry, so the older jump then misses.
- R7: A resolution that hits steps the entry's counter up by one when taken and down by one when not taken, holding at 3 and at 0.
- R8: A conditional hit (entry stored with `upd_cond`=1) predicts taken exactly when the counter is 2 or 3.
- R9: An unconditional hit (entry stored with `upd_cond`=0) predicts taken whatever its counter holds.
- R10: When a lookup and a resolution touch the same entry in the same cycle, the resolution is written and the lookup reports the contents from before it.
- R11: A resolution that hits writes its target and kind over the stored ones, and later lookups return the new target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lu_valid | input | 1 | Lookup request this cycle |
| lu_pc | input | ADDR_W | Fetch address to look up |
| upd_valid | input | 1 | Resolved jump this cycle |
| upd_pc | input | ADDR_W | Address of the resolved jump |
| upd_target | input | ADDR_W | Real target of the resolved jump |
| upd_taken | input | 1 | Resolved outcome, 1 = taken |
| upd_cond | input | 1 | 1 = conditional jump, 0 = unconditional |
| pred_hit | output | 1 | Previous cycle's lookup found its jump |
| pred_target | output | ADDR_W | Predicted target, 0 on a miss |
| pred_taken | output | 1 | Redirect hint for the previous lookup |

## Verification
A wrong tag, index or valid bit shows up at the first lookup of the affected address. It appears one cycle later as a spurious hit or a missing one. A corrupted counter can stay hidden while it remains on the same side of the midpoint. It only shows up after resolutions push it across, so the counter is walked through both clamps with a lookup after every step. The same-cycle collision and the eviction of a conflicting jump are each checked on the cycle they take effect and again on the cycle after.

// File: rtl/btb_pkg.sv
package btb_pkg;
  typedef logic [1:0] bias_t;

  localparam bias_t BIAS_MIN  = 2'd0;
  localparam bias_t BIAS_MAX  = 2'd3;
  localparam bias_t BIAS_WNT  = 2'd1;
  localparam bias_t BIAS_WTK  = 2'd2;

  // saturating step of a bias counter
  function automatic bias_t bias_step(input bias_t cur, input logic tk);
    if (tk) return (cur == BIAS_MAX) ? BIAS_MAX : bias_t'(cur + 2'd1);
    else    return (cur == BIAS_MIN) ? BIAS_MIN : bias_t'(cur - 2'd1);
  endfunction
endpackage

// File: rtl/btb_index.sv
module btb_index #(
  parameter int ADDR_W  = 32,
  parameter int IDX_W   = 4,
  parameter int ALIGN_W = 2,
  localparam int TAG_W  = ADDR_W - IDX_W - ALIGN_W
) (
  input  logic [ADDR_W-1:0] pc,
  output logic [IDX_W-1:0]  idx,
  output logic [TAG_W-1:0]  tag
);
  assign idx = pc[ALIGN_W +: IDX_W];
  assign tag = pc[ADDR_W-1 -: TAG_W];
endmodule

// File: rtl/btb_bias.sv
module btb_bias
  import btb_pkg::*;
(
  input  logic  hit,
  input  bias_t cur,
  input  logic  taken,
  output bias_t nxt
);
  always_comb begin
    if (hit)        nxt = bias_step(cur, taken);
    else if (taken) nxt = BIAS_WTK;
    else            nxt = BIAS_WNT;
  end
endmodule

// File: rtl/btb_store.sv
module btb_store
  import btb_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 4,
  parameter int TAG_W  = 26,
  localparam int DEPTH = 1 << IDX_W
) (
  input  logic              clk,
  input  logic              rst,
  // registered lookup port
  input  logic              rd_en,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic              rd_vld,
  output logic [TAG_W-1:0]  rd_tag,
  output logic [ADDR_W-1:0] rd_tgt,
  output bias_t             rd_bias,
  output logic              rd_cond,
  // asynchronous read for the update path
  input  logic [IDX_W-1:0]  up_idx,
  output logic              up_vld,
  output logic [TAG_W-1:0]  up_tag,
  output bias_t             up_bias,
  // write port
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [ADDR_W-1:0] wr_tgt,
  input  bias_t             wr_bias,
  input  logic              wr_cond
);
  logic [DEPTH-1:0]  vld;
  logic [TAG_W-1:0]  tag_m  [DEPTH];
  logic [ADDR_W-1:0] tgt_m  [DEPTH];
  bias_t             bias_m [DEPTH];
  logic              cond_m [DEPTH];

  // payload arrays: no reset, read-before-write on a shared address
  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_m[wr_idx]  <= wr_tag;
      tgt_m[wr_idx]  <= wr_tgt;
      bias_m[wr_idx] <= wr_bias;
      cond_m[wr_idx] <= wr_cond;
    end
    if (rd_en) begin
      rd_tag  <= tag_m[rd_idx];
      rd_tgt  <= tgt_m[rd_idx];
      rd_bias <= bias_m[rd_idx];
      rd_cond <= cond_m[rd_idx];
    end
  end

  // valid bits live in flops so they clear on reset
  always_ff @(posedge clk) begin
    if (rst) begin
      vld    <= '0;
      rd_vld <= 1'b0;
    end else begin
      if (wr_en) vld[wr_idx] <= 1'b1;
      if (rd_en) rd_vld <= vld[rd_idx];
    end
  end

  assign up_vld  = vld[up_idx];
  assign up_tag  = tag_m[up_idx];
  assign up_bias = bias_m[up_idx];
endmodule

// File: rtl/btb_top.sv
module btb_top
  import btb_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int IDX_W   = 4,
  parameter int ALIGN_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lu_valid,
  input  logic [ADDR_W-1:0] lu_pc,
  input  logic              upd_valid,
  input  logic [ADDR_W-1:0] upd_pc,
  input  logic [ADDR_W-1:0] upd_target,
  input  logic              upd_taken,
  input  logic              upd_cond,
  output logic              pred_hit,
  output logic [ADDR_W-1:0] pred_target,
  output logic              pred_taken
);
  localparam int TAG_W = ADDR_W - IDX_W - ALIGN_W;

  logic [IDX_W-1:0]  lu_idx, up_idx;
  logic [TAG_W-1:0]  lu_tag, up_tag;
  logic [TAG_W-1:0]  lu_tag_q;
  logic              lu_q;

  logic              rd_vld, rd_cond;
  logic [TAG_W-1:0]  rd_tag;
  logic [ADDR_W-1:0] rd_tgt;
  bias_t             rd_bias;

  logic              st_vld;
  logic [TAG_W-1:0]  st_tag;
  bias_t             st_bias, new_bias;
  logic              up_hit;

  btb_index #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .ALIGN_W(ALIGN_W)) u_lu_ix (
    .pc(lu_pc), .idx(lu_idx), .tag(lu_tag));

  btb_index #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .ALIGN_W(ALIGN_W)) u_up_ix (
    .pc(upd_pc), .idx(up_idx), .tag(up_tag));

  btb_store #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_store (
    .clk(clk), .rst(rst),
    .rd_en(lu_valid), .rd_idx(lu_idx),
    .rd_vld(rd_vld), .rd_tag(rd_tag), .rd_tgt(rd_tgt),
    .rd_bias(rd_bias), .rd_cond(rd_cond),
    .up_idx(up_idx), .up_vld(st_vld), .up_tag(st_tag), .up_bias(st_bias),
    .wr_en(upd_valid), .wr_idx(up_idx), .wr_tag(up_tag), .wr_tgt(upd_target),
    .wr_bias(new_bias), .wr_cond(upd_cond));

  assign up_hit = st_vld && (st_tag == up_tag);

  btb_bias u_bias (
    .hit(up_hit), .cur(st_bias), .taken(upd_taken), .nxt(new_bias));

  // lookup qualifier and tag travel alongside the array read
  always_ff @(posedge clk) begin
    if (rst) lu_q <= 1'b0;
    else     lu_q <= lu_valid;
    if (lu_valid) lu_tag_q <= lu_tag;
  end

  always_comb begin
    pred_hit    = lu_q && rd_vld && (rd_tag == lu_tag_q);
    pred_taken  = pred_hit && (!rd_cond || rd_bias[1]);
    pred_target = pred_hit ? rd_tgt : '0;
  end
endmodule

// File: rtl/btb_chk.sv
module btb_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              lu_valid,
  input logic [ADDR_W-1:0] lu_pc,
  input logic              upd_valid,
  input logic [ADDR_W-1:0] upd_pc,
  input logic [ADDR_W-1:0] upd_target,
  input logic              upd_cond,
  input logic              pred_hit,
  input logic [ADDR_W-1:0] pred_target,
  input logic              pred_taken
);
  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !lu_valid |=> (!pred_hit && !pred_taken));

  // R8
  taken_needs_hit_chk: assert property (@(posedge clk) disable iff (rst)
    pred_taken |-> pred_hit);

  // R4
  alloc_then_hit_chk: assert property (@(posedge clk) disable iff (rst)
    (lu_valid && $past(upd_valid) && lu_pc == $past(upd_pc))
      |=> (pred_hit && pred_target == $past(upd_target, 2)));

  // R9
  uncond_taken_chk: assert property (@(posedge clk) disable iff (rst)
    (lu_valid && $past(upd_valid) && !$past(upd_cond) && lu_pc == $past(upd_pc))
      |=> pred_taken);

  // R5
  miss_zero_tgt_chk: assert property (@(posedge clk) disable iff (rst)
    !pred_hit |-> (pred_target == '0));
endmodule

bind btb_top btb_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .lu_valid(lu_valid), .lu_pc(lu_pc),
  .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_target(upd_target),
  .upd_cond(upd_cond), .pred_hit(pred_hit), .pred_target(pred_target),
  .pred_taken(pred_taken));

// File: tb/btb_top_test.sv
`timescale 1ns/1ps
module btb_top_test;
  localparam int AW = 32;
  localparam int IW = 4;
  localparam int AL = 2;
  localparam int NE = 1 << IW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          lu_valid = 1'b0;
  logic [AW-1:0] lu_pc = '0;
  logic          upd_valid = 1'b0;
  logic [AW-1:0] upd_pc = '0;
  logic [AW-1:0] upd_target = '0;
  logic          upd_taken = 1'b0;
  logic          upd_cond = 1'b0;
  logic          pred_hit;
  logic [AW-1:0] pred_target;
  logic          pred_taken;

  int checks = 0;
  int errors = 0;
  logic mon_on = 1'b0;

  always #5 clk = ~clk;

  btb_top #(.ADDR_W(AW), .IDX_W(IW), .ALIGN_W(AL)) uut (
    .clk(clk), .rst(rst), .lu_valid(lu_valid), .lu_pc(lu_pc),
    .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_target(upd_target),
    .upd_taken(upd_taken), .upd_cond(upd_cond),
    .pred_hit(pred_hit), .pred_target(pred_target), .pred_taken(pred_taken));

  // reference table built from the requirements
  bit      m_v    [NE];
  int      m_tag  [NE];
  logic [AW-1:0] m_tgt [NE];
  int      m_ctr  [NE];
  bit      m_cond [NE];

  typedef struct {
    bit            hit;
    logic [AW-1:0] tgt;
    bit            tk;
    string         req;
  } exp_t;
  exp_t sb[$];

  function automatic logic [AW-1:0] mkpc(int tg, int ix);
    return (AW'(tg) << (IW + AL)) | (AW'(ix) << AL);
  endfunction

  function automatic int ix_of(logic [AW-1:0] p);
    return int'((p >> AL) & (NE - 1));
  endfunction

  function automatic int tg_of(logic [AW-1:0] p);
    return int'(p >> (IW + AL));
  endfunction

  task automatic chk(string req, string what, logic [AW-1:0] act, logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // one cycle of stimulus; expected lookup result taken before the update
  task automatic op(bit dl, logic [AW-1:0] lpc, bit du, logic [AW-1:0] upc,
                    logic [AW-1:0] utg, bit utk, bit ucd, string req);
    exp_t e;
    int i, t;
    @(negedge clk);
    lu_valid = dl; lu_pc = lpc;
    upd_valid = du; upd_pc = upc; upd_target = utg;
    upd_taken = utk; upd_cond = ucd;
    if (dl) begin
      i = ix_of(lpc); t = tg_of(lpc);
      e.hit = m_v[i] && m_tag[i] == t;
      e.tgt = e.hit ? m_tgt[i] : '0;
      e.tk  = e.hit && (!m_cond[i] || m_ctr[i] >= 2);
      e.req = req;
      sb.push_back(e);
    end
    if (du) begin
      i = ix_of(upc); t = tg_of(upc);
      if (m_v[i] && m_tag[i] == t) begin
        if (utk) m_ctr[i] = (m_ctr[i] == 3) ? 3 : m_ctr[i] + 1;
        else     m_ctr[i] = (m_ctr[i] == 0) ? 0 : m_ctr[i] - 1;
      end else begin
        m_v[i] = 1'b1; m_tag[i] = t;
        m_ctr[i] = utk ? 2 : 1;
      end
      m_tgt[i] = utg; m_cond[i] = ucd;
    end
  endtask

  task automatic look(logic [AW-1:0] p, string req);
    op(1'b1, p, 1'b0, '0, '0, 1'b0, 1'b0, req);
  endtask

  task automatic resolve(logic [AW-1:0] p, logic [AW-1:0] tg, bit tk, bit cd, string req);
    op(1'b0, '0, 1'b1, p, tg, tk, cd, req);
  endtask

  task automatic idle();
    op(1'b0, '0, 1'b0, '0, '0, 1'b0, 1'b0, "R2");
  endtask

  // monitor: one registered result per lookup
  always @(posedge clk) begin
    exp_t e;
    #1;
    if (mon_on) begin
      if (sb.size() > 0) begin
        e = sb.pop_front();
        chk(e.req, "hit", AW'(pred_hit), AW'(e.hit));
        chk(e.req, "target", pred_target, e.tgt);
        chk(e.req, "taken", AW'(pred_taken), AW'(e.tk));
      end else begin
        // R2: no lookup in the previous cycle
        chk("R2", "idle hit", AW'(pred_hit), '0);
        chk("R2", "idle taken", AW'(pred_taken), '0);
      end
    end
  end

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: outputs quiet straight after reset
        chk("R1", "reset hit", AW'(pred_hit), '0);
        chk("R1", "reset taken", AW'(pred_taken), '0);
        chk("R1", "reset target", pred_target, '0);
        mon_on = 1'b1;
        // R1: all entries empty
        for (int k = 0; k < NE; k++) look(mkpc(k * 3 + 1, k), "R1");
        // R4 R5 R8: first resolution allocates, later lookup hits
        look(mkpc(7, 1), "R4");
        resolve(mkpc(7, 1), 32'h0000_4000, 1'b1, 1'b1, "R4");
        look(mkpc(7, 1), "R5");
        // R3: other tag, same index; only top bit differs
        look(mkpc(8, 1), "R3");
        look(mkpc(7, 1) ^ 32'h8000_0000, "R3");
        look(mkpc(7, 2), "R3");
        // R4 R8: not-taken allocation predicts not taken
        resolve(mkpc(9, 2), 32'h0000_5000, 1'b0, 1'b1, "R4");
        look(mkpc(9, 2), "R8");
        // R7 R8: walk the counter through both clamps
        for (int k = 0; k < 4; k++) begin
          resolve(mkpc(9, 2), 32'h0000_5000, 1'b1, 1'b1, "R7");
          look(mkpc(9, 2), "R7");
        end
        for (int k = 0; k < 5; k++) begin
          resolve(mkpc(9, 2), 32'h0000_5000, 1'b0, 1'b1, "R7");
          look(mkpc(9, 2), "R8");
        end
        resolve(mkpc(9, 2), 32'h0000_5000, 1'b1, 1'b1, "R7");
        look(mkpc(9, 2), "R7");
        resolve(mkpc(9, 2), 32'h0000_5000, 1'b1, 1'b1, "R8");
        look(mkpc(9, 2), "R8");
        // R9: unconditional stays taken with counter driven to 0
        resolve(mkpc(11, 5), 32'h0000_6000, 1'b1, 1'b0, "R9");
        look(mkpc(11, 5), "R9");
        for (int k = 0; k < 3; k++) resolve(mkpc(11, 5), 32'h0000_6000, 1'b0, 1'b0, "R9");
        look(mkpc(11, 5), "R9");
        // R6: conflicting jump evicts the older one
        resolve(mkpc(12, 1), 32'h0000_7000, 1'b1, 1'b1, "R6");
        look(mkpc(7, 1), "R6");
        look(mkpc(12, 1), "R6");
        // R11: new target on a hit overwrites
        resolve(mkpc(12, 1), 32'h0000_7100, 1'b1, 1'b1, "R11");
        look(mkpc(12, 1), "R11");
        // R10: same-cycle lookup sees old contents
        op(1'b1, mkpc(12, 1), 1'b1, mkpc(12, 1), 32'h0000_7200, 1'b0, 1'b1, "R10");
        look(mkpc(12, 1), "R10");
        op(1'b1, mkpc(13, 9), 1'b1, mkpc(13, 9), 32'h0000_8000, 1'b1, 1'b1, "R10");
        look(mkpc(13, 9), "R10");
        // R4: allocation immediately followed by a lookup
        op(1'b0, '0, 1'b1, mkpc(14, 15), 32'h0000_9000, 1'b1, 1'b0, "R4");
        look(mkpc(14, 15), "R4");
        idle(); idle(); idle();
        @(negedge clk);
      end
      begin
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired");
      end
    join_any
    disable fork;
    if (sb.size() != 0) begin
      errors++; checks++;
      $display("FAIL R2 pending=%0d expected=0", sb.size());
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule